// File: doc/BRIEF.md
# Single-Line Serial Page Write Decoder

This block is the device-side control for a memory that takes its whole address and data stream one bit at a time on a single I/O line. The line is qualified by ordinary bus strobes: an active-low chip enable, write enable and output enable. A write cycle (chip enable and write enable low, output enable high) delivers one bit. A read cycle (chip enable and output enable low, write enable high) delivers no data; it acts as a sequence marker and returns a busy status on the line. The strobes arrive asynchronously. They are synchronised to a system clock, and a bit is taken when write enable rises while chip enable is low.

A write begins with a reset step, which is a read cycle followed by a write of 0. The reset step sets a write-enable latch. Sixteen address bits follow, most significant first. Whole bytes are then loaded into a 32-byte page buffer. Loading starts at the address offset within the page and wraps at the page end. The commit is a read cycle, a write of 1, and a second read cycle. On the second read the loaded bytes move into a small register array that stands in for the nonvolatile cells. The block then stays busy for a parameterised number of clocks. Any broken sequence clears the latch and nothing is stored. A combinational peek port exposes the array contents so that committed data can be observed.

Top module: `serial_page_writer`

## Requirements
- R1: After reset, io_oe is 0, every array byte reads 0 through the peek port, and a status read returns io_out = 1.
- R2: A reset step (a read cycle, then a write cycle whose bit is 0) sets the write-enable latch and begins address capture. A write of 1 that directly follows a read cycle, with no completed load before it, abandons the sequence.
- R3: Address capture takes 16 write cycles, most significant bit first. If any address bit at or above log2(ARRAY_BYTES) is 1, which includes bits 15 and 14, the commit is refused and the array is left unchanged.
- R4: Data bytes arrive most significant bit first. Byte k is stored at page offset (addr[4:0] + k) mod 32, inside the 32-byte page selected by the address. A commit writes only the offsets that were loaded.
- R5: Loading wraps from offset 31 to offset 0 of the same page. The 33rd byte of a load overwrites the 1st byte.
- R6: A commit starts only on the pattern read, write 1, read, after at least one whole byte has been loaded. If the loaded bit count is not a multiple of 8, nothing is stored and no busy period follows.
- R7: A read cycle in the middle of address capture, or a sequence that lacks the reset step, clears the latch. Any commit pattern that follows it stores nothing.
- R8: After a commit starts, status reads return io_out = 0 for BUSY_CYCLES clocks and 1 afterwards. A reset step or other writes issued during the busy period leave the status and the array unchanged.
- R9: Strobe activity while chip enable is high is ignored, so a load that is interrupted by such activity still commits correctly.
- R10: io_oe is 1 only during a read cycle. It stays 0 while write enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low; the bit is taken on its rising edge |
| oe_n | input | 1 | Output enable, active low |
| io_in | input | 1 | Serial bit input from the I/O line |
| io_out | output | 1 | Status driven onto the I/O line (0 while busy) |
| io_oe | output | 1 | Drive enable for the I/O line |
| peek_addr | input | $clog2(ARRAY_BYTES) | Array byte to observe |
| peek_data | output | 8 | Contents of the selected array byte |

## Verification
The bench builds the block with ARRAY_BYTES = 64 and BUSY_CYCLES = 100. With a 64-byte array there are two pages, so page selection, wrap within the second page, and refusal of any address at or above 0x0040 can all be reached with short loads. A busy period of 100 clocks is long enough for a full reset step and several status reads to land inside it, and short enough that the end of the busy period is seen within a few hundred clocks.

// File: rtl/serial_page_writer.sv
module serial_page_writer #(
  parameter int ADDR_W      = 16,
  parameter int PAGE_BYTES  = 32,
  parameter int ARRAY_BYTES = 128,
  parameter int BUSY_CYCLES = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ce_n,
  input  logic                           we_n,
  input  logic                           oe_n,
  input  logic                           io_in,
  output logic                           io_out,
  output logic                           io_oe,
  input  logic [$clog2(ARRAY_BYTES)-1:0] peek_addr,
  output logic [7:0]                     peek_data
);
  localparam int PG_AW  = $clog2(PAGE_BYTES);
  localparam int ARR_AW = $clog2(ARRAY_BYTES);
  localparam int ACNT_W = $clog2(ADDR_W);
  localparam int BCNT_W = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_ADDR, S_DATA, S_ENDRD, S_ARM, S_BUSY} st_t;

  logic [1:0] ce_q, io_q;
  logic [2:0] we_q, oe_q;
  st_t st;
  logic wel;
  logic [ADDR_W-1:0] addr_sr;
  logic [ACNT_W-1:0] acnt;
  logic [6:0] sr7;
  logic [2:0] bitc;
  logic [PG_AW-1:0] ptr;
  logic [PAGE_BYTES-1:0] loaded;
  logic [7:0] pbuf [PAGE_BYTES];
  logic [7:0] mem [ARRAY_BYTES];
  logic [BCNT_W-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_q <= '1; we_q <= '1; oe_q <= '1; io_q <= '0;
    end else begin
      ce_q <= {ce_q[0], ce_n};
      we_q <= {we_q[1:0], we_n};
      oe_q <= {oe_q[1:0], oe_n};
      io_q <= {io_q[0], io_in};
    end
  end

  wire bit_in = io_q[1];
  wire wr_ev  = we_q[1] & ~we_q[2] & ~ce_q[1] & oe_q[1];
  wire rd_ev  = oe_q[1] & ~oe_q[2] & ~ce_q[1] & we_q[1];
  wire addr_ok = (addr_sr[ADDR_W-1:ARR_AW] == '0);
  wire load_ok = (bitc == 3'd0) && (|loaded) && addr_ok;
  wire [ARR_AW-PG_AW-1:0] page_base = addr_sr[ARR_AW-1:PG_AW];

  assign io_oe     = ~ce_q[1] & ~oe_q[1] & we_q[1];
  assign io_out    = (st != S_BUSY);
  assign peek_data = mem[peek_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; wel <= 1'b0; addr_sr <= '0; acnt <= '0; sr7 <= '0;
      bitc <= '0; ptr <= '0; loaded <= '0; bcnt <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
      for (int i = 0; i < ARRAY_BYTES; i++) mem[i] <= '0;
    end else if (st == S_BUSY) begin
      if (bcnt == BCNT_W'(BUSY_CYCLES - 1)) begin
        st  <= S_IDLE;
        wel <= 1'b0;
      end else bcnt <= bcnt + 1'b1;
    end else if (rd_ev) begin
      if (st == S_DATA && load_ok) st <= S_ENDRD;
      else if (st == S_ARM) begin
        st   <= S_BUSY;
        bcnt <= '0;
        for (int i = 0; i < PAGE_BYTES; i++)
          if (loaded[i]) mem[{page_base, PG_AW'(i)}] <= pbuf[i];
      end else begin
        st  <= S_RD;
        wel <= 1'b0;
      end
    end else if (wr_ev) begin
      case (st)
        S_RD, S_ENDRD: begin
          if (!bit_in) begin
            st <= S_ADDR; wel <= 1'b1; acnt <= '0; loaded <= '0;
          end else if (st == S_ENDRD && wel) st <= S_ARM;
          else begin
            st <= S_IDLE; wel <= 1'b0;
          end
        end
        S_ADDR: begin
          addr_sr <= {addr_sr[ADDR_W-2:0], bit_in};
          acnt    <= acnt + 1'b1;
          if (acnt == ACNT_W'(ADDR_W - 1)) begin
            st   <= S_DATA;
            ptr  <= {addr_sr[PG_AW-2:0], bit_in};
            bitc <= '0;
          end
        end
        S_DATA: begin
          sr7  <= {sr7[5:0], bit_in};
          bitc <= bitc + 1'b1;
          if (bitc == 3'd7) begin
            pbuf[ptr]   <= {sr7, bit_in};
            loaded[ptr] <= 1'b1;
            ptr         <= ptr + 1'b1;
          end
        end
        S_ARM: begin
          st <= S_IDLE; wel <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assert_commit_from_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BUSY && $past(st) != S_BUSY) |-> ($past(st) == S_ARM && $past(rd_ev)));
  assert_latch_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_BUSY && st != S_BUSY) |-> !wel);
  assert_busy_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BUSY) |-> (bcnt < BCNT_W'(BUSY_CYCLES)));
  assert_addr_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && $past(st) == S_ADDR) |-> ($past(acnt) == ACNT_W'(ADDR_W - 1)));
  assert_arm_needs_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ARM || st == S_ENDRD) |-> wel);
  assert_no_drive_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_q[1]) |-> !io_oe);
endmodule

// File: tb/serial_page_writer_bench.sv
module serial_page_writer_bench;
  localparam int AB = 64;
  localparam int BC = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, io_in = 1'b0;
  logic io_out, io_oe;
  logic [5:0] peek_addr = '0;
  logic [7:0] peek_data;

  int checks = 0, errors = 0;
  logic [7:0] model [AB];
  bit    expq [$];
  string tagq [$];
  bit    oe_prev = 1'b0;
  bit    done = 1'b0;

  always #4 clk = ~clk;

  serial_page_writer #(.ARRAY_BYTES(AB), .BUSY_CYCLES(BC)) u_serial_page_writer (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe), .peek_addr(peek_addr), .peek_data(peek_data));

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (io_oe && !oe_prev) begin
      if (expq.size() == 0) chk(1'b0, "R10 unexpected drive", 1, 0);
      else begin
        automatic bit e = expq.pop_front();
        automatic string t = tagq.pop_front();
        chk(io_out == e, t, io_out, e);
      end
    end
    oe_prev = io_oe;
  end

  task automatic tick(int n); repeat (n) @(posedge clk); endtask

  task automatic wbit(bit b);
    @(negedge clk) ce_n = 1'b0; io_in = b;
    tick(2); @(negedge clk) we_n = 1'b0;
    tick(4); @(negedge clk) we_n = 1'b1;
    tick(4); @(negedge clk) ce_n = 1'b1;
    tick(2);
  endtask

  task automatic rcyc(bit e, string tag);
    expq.push_back(e); tagq.push_back(tag);
    @(negedge clk) ce_n = 1'b0;
    tick(2); @(negedge clk) oe_n = 1'b0;
    tick(6); @(negedge clk) oe_n = 1'b1;
    tick(4); @(negedge clk) ce_n = 1'b1;
    tick(2);
  endtask

  task automatic send_addr(logic [15:0] a);
    for (int i = 15; i >= 0; i--) wbit(a[i]);
  endtask

  task automatic send_byte(logic [7:0] d);
    for (int i = 7; i >= 0; i--) wbit(d[i]);
  endtask

  task automatic noise();
    io_in = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) we_n = 1'b0; tick(4);
      @(negedge clk) we_n = 1'b1; tick(4);
      @(negedge clk) oe_n = 1'b0; tick(4);
      @(negedge clk) oe_n = 1'b1; tick(4);
    end
  endtask

  task automatic check_mem(string req);
    int bad = -1;
    for (int i = 0; i < AB; i++) begin
      peek_addr = 6'(i); #1;
      if (bad < 0 && peek_data !== model[i]) bad = i;
    end
    if (bad < 0) chk(1'b1, req, 0, 0);
    else begin
      peek_addr = 6'(bad); #1;
      chk(1'b0, $sformatf("%s byte %0d", req, bad), peek_data, model[bad]);
    end
  endtask

  task automatic full_write(logic [15:0] a, int n, logic [7:0] seed, bit with_noise, string req);
    bit ok = (a[15:6] == '0);
    rcyc(1'b1, {req, " pre status"}); wbit(1'b0);
    send_addr(a);
    for (int k = 0; k < n; k++) begin
      automatic logic [7:0] d = seed + 8'(k * 13);
      send_byte(d);
      if (with_noise && k == 0) noise();
      if (ok) model[{a[5], 5'(a[4:0] + 5'(k))}] = d;
    end
    rcyc(1'b1, {req, " end-load read"}); wbit(1'b1); rcyc(1'b1, {req, " launch read"});
    rcyc(!ok, {req, " busy status"});
    tick(BC + 30);
    rcyc(1'b1, {req, " done status"});
    check_mem(req);
  endtask

  initial begin
    for (int i = 0; i < AB; i++) model[i] = '0;
    tick(5);
    @(negedge clk) rst_n = 1'b1;
    tick(2);
    chk(io_oe == 1'b0, "R1 io_oe after reset", io_oe, 0);
    check_mem("R1 array cleared");
    rcyc(1'b1, "R1 idle status");

    full_write(16'h0003, 2, 8'hA5, 1'b0, "R4 basic load");

    @(negedge clk) ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    tick(5);
    chk(io_oe == 1'b0, "R10 no drive with write strobe low", io_oe, 0);
    @(negedge clk) ce_n = 1'b1; tick(3);
    @(negedge clk) we_n = 1'b1; oe_n = 1'b1; tick(3);

    full_write(16'h003E, 4, 8'h11, 1'b0, "R5 wrap in page");
    full_write(16'h0020, 33, 8'h40, 1'b0, "R5 overrun overwrites");
    full_write(16'h4005, 1, 8'h77, 1'b0, "R3 high bits set");
    full_write(16'h0045, 1, 8'h78, 1'b0, "R3 beyond array");
    full_write(16'h0010, 2, 8'h12, 1'b1, "R9 noise with CE high");

    rcyc(1'b1, "R6 pre"); wbit(1'b0); send_addr(16'h0001); send_byte(8'hFF);
    for (int i = 0; i < 4; i++) wbit(1'b1);
    rcyc(1'b1, "R6 end read"); wbit(1'b1); rcyc(1'b1, "R6 launch read");
    rcyc(1'b1, "R6 partial byte not busy");
    check_mem("R6 partial byte stores nothing");

    rcyc(1'b1, "R2 pre"); wbit(1'b1); send_addr(16'h0002); send_byte(8'h99);
    rcyc(1'b1, "R2 end read"); wbit(1'b1); rcyc(1'b1, "R2 launch read");
    rcyc(1'b1, "R2 no reset step not busy");
    check_mem("R2 no reset step stores nothing");

    rcyc(1'b1, "R7 pre"); wbit(1'b0); send_addr(16'h0000);
    for (int i = 0; i < 8; i++) wbit(1'b0);
    rcyc(1'b1, "R7 read mid-address");
    for (int i = 0; i < 8; i++) wbit(1'b1);
    send_byte(8'h55);
    rcyc(1'b1, "R7 end read"); wbit(1'b1); rcyc(1'b1, "R7 launch read");
    rcyc(1'b1, "R7 broken not busy");
    check_mem("R7 broken stores nothing");

    rcyc(1'b1, "R8 pre"); wbit(1'b0); send_addr(16'h0008); send_byte(8'hC3);
    model[8] = 8'hC3;
    rcyc(1'b1, "R8 end read"); wbit(1'b1); rcyc(1'b1, "R8 launch read");
    rcyc(1'b0, "R8 busy"); wbit(1'b0);
    rcyc(1'b0, "R8 reset during commit");
    wbit(1'b0); wbit(1'b1);
    tick(BC + 30);
    rcyc(1'b1, "R8 done");
    check_mem("R8 commit and ignored writes");

    tick(10);
    chk(expq.size() == 0, "R10 all reads observed", expq.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(200000);
    if (!done) begin
      chk(1'b0, "watchdog", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule